// File: doc/BRIEF.md
# Fault Alarm and Scale-Limit Controller

This block sits between the comparator bank of a bridge-sensor conditioner and its output stage. It receives one flag for each of four sensor-input level comparators (positive and negative input, each too high and too low) and one flag for each of five front-end amplifier monitors (saturation and common-mode checks). Every flag is brought into the clock domain through a two-flop synchronizer and must stay at a new value for four clocks before the block treats it as changed. A sensor-input fault then drives a rail-override command that pins the conditioned output to the high or the low rail, as one polarity bit chooses. This happens whether or not the output limiter is enabled.

The front-end monitors are gated one by one by an enable mask. Enabled ones are only logged, and they never move the output. Every logged flag sets a sticky bit in a status word that a host samples and clears with a read strobe. The block also turns a 6-bit limit configuration into two one-hot threshold selects, one for the over-scale comparator and one for the under-scale comparator of the output limiter.

Top module: `fault_limit_ctrl`

## Requirements
- R1: While rst_n is low, and after its release until a flag qualifies, ovr_hi_o, ovr_lo_o, stat_o, thr_hi_sel_o and thr_lo_sel_o are all zero.
- R2: A high level on any bit of sens_cmp_i drives the override 7 clock edges after it is applied. With alarm_hi_i=1 it drives ovr_hi_o=1, and with alarm_hi_i=0 it drives ovr_lo_o=1. The two override outputs are never high together.
- R3: The override of R2 does not depend on limit_en_i.
- R4: When every sensor flag has been low for 7 clock edges, the override outputs return to 0, even while the status bits are still set.
- R5: A flag pulse that lasts 3 clocks has no effect on the override or on stat_o. A pulse that lasts 4 clocks is accepted.
- R6: The status word stat_o has bits 3:0 equal to sens_cmp_i bits 3:0 and bits 8:4 equal to fe_cmp_i bits 4:0. A front-end flag sets its status bit only if its fe_en_i bit is 1. Front-end flags never drive the override.
- R7: Status bits are sticky. The clock edge at which rd_stat_i is high clears them, except for bits whose qualified flag is still high, and those stay set.
- R8: With limit_en_i=1, thr_hi_sel_o is one-hot with bit (7 - lim_cfg_i[5:3]) set, one edge after the inputs change. Code 000 therefore selects bit 7, the highest over-scale threshold.
- R9: With limit_en_i=1, thr_lo_sel_o is one-hot with bit lim_cfg_i[2:0] set, one edge after the inputs change. Code 111 therefore selects bit 7, the highest under-scale threshold.
- R10: With limit_en_i=0, both threshold selects are zero one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sens_cmp_i | input | 4 | Raw sensor-input comparator flags |
| fe_cmp_i | input | 5 | Raw front-end monitor flags |
| fe_en_i | input | 5 | Enable mask for the front-end flags |
| alarm_hi_i | input | 1 | Rail polarity on a sensor fault (1 = high rail) |
| limit_en_i | input | 1 | Enables the output limiter threshold selects |
| lim_cfg_i | input | 6 | Over-scale code in [5:3], under-scale code in [2:0] |
| rd_stat_i | input | 1 | Status read strobe; clears the sticky bits |
| ovr_hi_o | output | 1 | Force the output to the high rail |
| ovr_lo_o | output | 1 | Force the output to the low rail |
| stat_o | output | 9 | Sticky alarm status word |
| thr_hi_sel_o | output | 8 | One-hot over-scale threshold select |
| thr_lo_sel_o | output | 8 | One-hot under-scale threshold select |

## Verification
A flag change reaches the override and status outputs on the seventh rising edge after it is applied. That count is two synchronizer stages, four qualification clocks and one output register. The bench drives its stimulus at a falling edge, counts exactly seven rising edges, and samples at the following falling edge. It also samples once after six edges to show that the change has not arrived early. The threshold selects and the read-clear take effect on the first rising edge, so those checks wait one edge. The glitch cases wait well past the seven-edge point before they check that nothing changed.

// File: rtl/fault_limit_pkg.sv
package fault_limit_pkg;

    localparam int SENS_FLAGS  = 4;
    localparam int FE_FLAGS    = 5;
    localparam int SYNC_DEPTH  = 2;
    localparam int QUAL_CLOCKS = 4;
    localparam int THR_CODE_W  = 3;

    typedef enum logic [1:0] {
        RAIL_NONE = 2'b00,
        RAIL_LOW  = 2'b01,
        RAIL_HIGH = 2'b10
    } rail_cmd_e;

endpackage

// File: rtl/fault_sync_filter.sv
module fault_sync_filter #(
    parameter int W     = 9,
    parameter int DEPTH = 2,
    parameter int HOLD  = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] qual_o
);

    localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] chain;
        logic [W-1:0]            qual;
        logic [W-1:0][CW-1:0]    run;
    } filt_state_t;

    filt_state_t st_d, st_q;

    // Next state: shift the synchronizer, then count agreement per bit
    always_comb begin
        st_d = st_q;
        st_d.chain[0] = raw_i;
        for (int s = 1; s < DEPTH; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        for (int b = 0; b < W; b++) begin
            if (st_q.chain[DEPTH-1][b] != st_q.qual[b]) begin
                if (st_q.run[b] == CW'(HOLD - 1)) begin
                    st_d.qual[b] = st_q.chain[DEPTH-1][b];
                    st_d.run[b]  = '0;
                end else begin
                    st_d.run[b] = st_q.run[b] + CW'(1);
                end
            end else begin
                st_d.run[b] = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign qual_o = st_q.qual;

endmodule

// File: rtl/alarm_core.sv
module alarm_core
    import fault_limit_pkg::*;
#(
    parameter int SENS_N = 4,
    parameter int FE_N   = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SENS_N-1:0]      sens_qual_i,
    input  logic [FE_N-1:0]        fe_qual_i,
    input  logic [FE_N-1:0]        fe_en_i,
    input  logic                   pol_hi_i,
    input  logic                   rd_i,
    output logic                   ovr_hi_o,
    output logic                   ovr_lo_o,
    output logic [SENS_N+FE_N-1:0] stat_o
);

    localparam int SW = SENS_N + FE_N;

    typedef struct packed {
        rail_cmd_e     rail;
        logic [SW-1:0] stat;
    } alarm_state_t;

    alarm_state_t st_d, st_q;
    logic [SW-1:0] live;
    logic          sens_any;

    always_comb begin
        live     = {fe_qual_i & fe_en_i, sens_qual_i};
        sens_any = |sens_qual_i;
        st_d     = st_q;
        // Status bits: a read clears, a live flag sets, and set wins
        st_d.stat = (rd_i ? '0 : st_q.stat) | live;
        // Only sensor-input faults move the output
        if (!sens_any) begin
            st_d.rail = RAIL_NONE;
        end else if (pol_hi_i) begin
            st_d.rail = RAIL_HIGH;
        end else begin
            st_d.rail = RAIL_LOW;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{rail: RAIL_NONE, stat: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ovr_hi_o = (st_q.rail == RAIL_HIGH);
    assign ovr_lo_o = (st_q.rail == RAIL_LOW);
    assign stat_o   = st_q.stat;

endmodule

// File: rtl/scale_thresh_decode.sv
module scale_thresh_decode #(
    parameter int CODE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     en_i,
    input  logic [CODE_W-1:0]        over_code_i,
    input  logic [CODE_W-1:0]        under_code_i,
    output logic [(1<<CODE_W)-1:0]   over_sel_o,
    output logic [(1<<CODE_W)-1:0]   under_sel_o
);

    localparam int SEL_W = 1 << CODE_W;

    typedef struct packed {
        logic [SEL_W-1:0] over_sel;
        logic [SEL_W-1:0] under_sel;
    } thr_state_t;

    thr_state_t st_d, st_q;

    // Over-scale codes run downward from the top threshold, under-scale codes upward
    always_comb begin
        st_d = '0;
        for (int i = 0; i < SEL_W; i++) begin
            st_d.over_sel[i]  = en_i && (over_code_i  == CODE_W'(SEL_W - 1 - i));
            st_d.under_sel[i] = en_i && (under_code_i == CODE_W'(i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign over_sel_o  = st_q.over_sel;
    assign under_sel_o = st_q.under_sel;

endmodule

// File: rtl/fault_limit_ctrl.sv
module fault_limit_ctrl
    import fault_limit_pkg::*;
#(
    parameter int SENS_N = SENS_FLAGS,
    parameter int FE_N   = FE_FLAGS,
    parameter int SYNC_N = SYNC_DEPTH,
    parameter int QUAL_N = QUAL_CLOCKS,
    parameter int CODE_W = THR_CODE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SENS_N-1:0]        sens_cmp_i,
    input  logic [FE_N-1:0]          fe_cmp_i,
    input  logic [FE_N-1:0]          fe_en_i,
    input  logic                     alarm_hi_i,
    input  logic                     limit_en_i,
    input  logic [2*CODE_W-1:0]      lim_cfg_i,
    input  logic                     rd_stat_i,
    output logic                     ovr_hi_o,
    output logic                     ovr_lo_o,
    output logic [SENS_N+FE_N-1:0]   stat_o,
    output logic [(1<<CODE_W)-1:0]   thr_hi_sel_o,
    output logic [(1<<CODE_W)-1:0]   thr_lo_sel_o
);

    localparam int FLAG_W = SENS_N + FE_N;

    logic [FLAG_W-1:0] qual;

    fault_sync_filter #(
        .W     (FLAG_W),
        .DEPTH (SYNC_N),
        .HOLD  (QUAL_N)
    ) u_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({fe_cmp_i, sens_cmp_i}),
        .qual_o (qual)
    );

    alarm_core #(
        .SENS_N (SENS_N),
        .FE_N   (FE_N)
    ) u_alarm (
        .clk         (clk),
        .rst_n       (rst_n),
        .sens_qual_i (qual[SENS_N-1:0]),
        .fe_qual_i   (qual[FLAG_W-1:SENS_N]),
        .fe_en_i     (fe_en_i),
        .pol_hi_i    (alarm_hi_i),
        .rd_i        (rd_stat_i),
        .ovr_hi_o    (ovr_hi_o),
        .ovr_lo_o    (ovr_lo_o),
        .stat_o      (stat_o)
    );

    scale_thresh_decode #(
        .CODE_W (CODE_W)
    ) u_thr (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (limit_en_i),
        .over_code_i  (lim_cfg_i[2*CODE_W-1:CODE_W]),
        .under_code_i (lim_cfg_i[CODE_W-1:0]),
        .over_sel_o   (thr_hi_sel_o),
        .under_sel_o  (thr_lo_sel_o)
    );

endmodule

// File: rtl/fault_limit_ctrl_chk.sv
module fault_limit_ctrl_chk #(
    parameter int SENS_N = 4,
    parameter int FE_N   = 5,
    parameter int CODE_W = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     alarm_hi_i,
    input logic                     limit_en_i,
    input logic                     rd_stat_i,
    input logic                     ovr_hi_o,
    input logic                     ovr_lo_o,
    input logic [SENS_N+FE_N-1:0]   stat_o,
    input logic [(1<<CODE_W)-1:0]   thr_hi_sel_o,
    input logic [(1<<CODE_W)-1:0]   thr_lo_sel_o
);

    logic seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else begin
            seen_q <= 1'b1;
        end
    end

    p_rail_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovr_hi_o && ovr_lo_o));

    p_rail_pol_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && ovr_hi_o |-> $past(alarm_hi_i));

    p_ovr_from_sensor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_hi_o || ovr_lo_o) |-> (|stat_o[SENS_N-1:0]));

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !$past(rd_stat_i) |-> ((stat_o & $past(stat_o)) == $past(stat_o)));

    p_hi_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(limit_en_i) |-> $countones(thr_hi_sel_o) == 1);

    p_lo_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && $past(limit_en_i) |-> $countones(thr_lo_sel_o) == 1);

    p_sel_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && !$past(limit_en_i) |-> (thr_hi_sel_o == '0) && (thr_lo_sel_o == '0));

    p_sel_sparse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(thr_hi_sel_o) && $onehot0(thr_lo_sel_o));

endmodule

bind fault_limit_ctrl fault_limit_ctrl_chk #(
    .SENS_N (SENS_N),
    .FE_N   (FE_N),
    .CODE_W (CODE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .alarm_hi_i   (alarm_hi_i),
    .limit_en_i   (limit_en_i),
    .rd_stat_i    (rd_stat_i),
    .ovr_hi_o     (ovr_hi_o),
    .ovr_lo_o     (ovr_lo_o),
    .stat_o       (stat_o),
    .thr_hi_sel_o (thr_hi_sel_o),
    .thr_lo_sel_o (thr_lo_sel_o)
);

// File: tb/fault_limit_ctrl_bench.sv
`timescale 1ns/1ps
module fault_limit_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sens_cmp_i = '0;
    logic [4:0] fe_cmp_i = '0;
    logic [4:0] fe_en_i = '0;
    logic       alarm_hi_i = 1'b0;
    logic       limit_en_i = 1'b0;
    logic [5:0] lim_cfg_i = '0;
    logic       rd_stat_i = 1'b0;
    logic       ovr_hi_o, ovr_lo_o;
    logic [8:0] stat_o;
    logic [7:0] thr_hi_sel_o, thr_lo_sel_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    fault_limit_ctrl u_fault_limit_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .sens_cmp_i   (sens_cmp_i),
        .fe_cmp_i     (fe_cmp_i),
        .fe_en_i      (fe_en_i),
        .alarm_hi_i   (alarm_hi_i),
        .limit_en_i   (limit_en_i),
        .lim_cfg_i    (lim_cfg_i),
        .rd_stat_i    (rd_stat_i),
        .ovr_hi_o     (ovr_hi_o),
        .ovr_lo_o     (ovr_lo_o),
        .stat_o       (stat_o),
        .thr_hi_sel_o (thr_hi_sel_o),
        .thr_lo_sel_o (thr_lo_sel_o)
    );

    // {limit_en, cfg[5:3], cfg[2:0], expected over select, expected under select}
    localparam int NVEC = 10;
    localparam logic [22:0] VEC [NVEC] = '{
        {1'b1, 3'b000, 3'b000, 8'h80, 8'h01},
        {1'b1, 3'b001, 3'b111, 8'h40, 8'h80},
        {1'b1, 3'b111, 3'b011, 8'h01, 8'h08},
        {1'b1, 3'b010, 3'b101, 8'h20, 8'h20},
        {1'b1, 3'b100, 3'b010, 8'h08, 8'h04},
        {1'b1, 3'b011, 3'b110, 8'h10, 8'h40},
        {1'b1, 3'b101, 3'b001, 8'h04, 8'h02},
        {1'b1, 3'b110, 3'b100, 8'h02, 8'h10},
        {1'b0, 3'b000, 3'b111, 8'h00, 8'h00},
        {1'b0, 3'b101, 3'b010, 8'h00, 8'h00}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_clear();
        rd_stat_i = 1'b1;
        tick(1);
        rd_stat_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        tick(3);
        check("R1 ovr in reset", {14'd0, ovr_hi_o, ovr_lo_o}, 16'd0);
        check("R1 stat in reset", {7'd0, stat_o}, 16'd0);
        rst_n = 1'b1;
        tick(2);
        check("R1 thr after reset", {thr_hi_sel_o, thr_lo_sel_o}, 16'd0);
        check("R1 stat after reset", {7'd0, stat_o}, 16'd0);

        // R8 R9 R10: threshold decode table
        for (int v = 0; v < NVEC; v++) begin
            limit_en_i = VEC[v][22];
            lim_cfg_i  = VEC[v][21:16];
            tick(1);
            check("R8 over select", {8'd0, thr_hi_sel_o}, {8'd0, VEC[v][15:8]});
            check("R9 under select", {8'd0, thr_lo_sel_o}, {8'd0, VEC[v][7:0]});
            if (!VEC[v][22]) check("R10 limiter off", {thr_hi_sel_o, thr_lo_sel_o}, 16'd0);
        end
        limit_en_i = 1'b0;

        // R2 R3 R4 R7: each sensor flag, alternating polarity and limiter enable
        for (int b = 0; b < 4; b++) begin
            alarm_hi_i = b[0];
            limit_en_i = b[1];
            sens_cmp_i = 4'(1 << b);
            tick(6);
            check("R2 not before edge 7", {14'd0, ovr_hi_o, ovr_lo_o}, 16'd0);
            tick(1);
            check("R2 R3 override rail", {14'd0, ovr_hi_o, ovr_lo_o},
                  {14'd0, b[0] == 1'b1, b[0] == 1'b0});
            check("R6 sensor status bit", {7'd0, stat_o}, 16'(1 << b));
            sens_cmp_i = '0;
            tick(7);
            check("R4 override released", {14'd0, ovr_hi_o, ovr_lo_o}, 16'd0);
            check("R7 status sticky", {7'd0, stat_o}, 16'(1 << b));
            read_clear();
            check("R7 read clears", {7'd0, stat_o}, 16'd0);
        end
        limit_en_i = 1'b0;
        alarm_hi_i = 1'b1;

        // R5: a 3-clock glitch is ignored
        sens_cmp_i = 4'b0100;
        tick(3);
        sens_cmp_i = '0;
        tick(12);
        check("R5 short pulse ovr", {14'd0, ovr_hi_o, ovr_lo_o}, 16'd0);
        check("R5 short pulse stat", {7'd0, stat_o}, 16'd0);

        // R5: a 4-clock pulse is accepted
        sens_cmp_i = 4'b0010;
        tick(4);
        sens_cmp_i = '0;
        tick(3);
        check("R5 4-clock pulse ovr", {14'd0, ovr_hi_o, ovr_lo_o}, 16'h2);
        tick(8);
        check("R5 4-clock pulse stat", {7'd0, stat_o}, 16'h002);
        read_clear();

        // R6: enabled front-end flags are logged only
        fe_en_i  = 5'b10101;
        fe_cmp_i = 5'b11111;
        tick(10);
        check("R6 front-end no override", {14'd0, ovr_hi_o, ovr_lo_o}, 16'd0);
        check("R6 front-end masked status", {7'd0, stat_o}, 16'h150);
        fe_cmp_i = '0;
        tick(8);
        read_clear();
        check("R6 front-end cleared", {7'd0, stat_o}, 16'd0);

        // R7: a read while a flag is live leaves that bit set
        alarm_hi_i = 1'b0;
        sens_cmp_i = 4'b1000;
        tick(8);
        read_clear();
        check("R7 live bit survives read", {7'd0, stat_o}, 16'h008);
        check("R2 low rail held", {14'd0, ovr_hi_o, ovr_lo_o}, 16'h1);
        sens_cmp_i = '0;
        tick(8);
        read_clear();
        check("R7 cleared after release", {7'd0, stat_o}, 16'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule